// File: doc/BRIEF.md
# Link ECC Checker with Error-Persistence Alarm

This block sits on the receive side of one segment of a board-to-board link. Each beat carries two protected words, a narrow control word and a wide data word. Each word is encoded with an extended Hamming code that corrects one bit and detects two. The block decodes both words and corrects any single-bit error before the output register, so a clean beat and a corrected beat take the same time. A data word that cannot be corrected leaves the block with a poison tag so that later consumers discard it. A control word that cannot be corrected raises a checkstop request, because the link protocol can no longer be trusted.

The block also watches how often corrections happen. A minute tick from the system closes each observation interval. The block keeps a short history that records whether each interval saw at least one corrected beat. When the configured number of consecutive intervals all saw corrections, it raises a sticky service alarm. Correction continues as normal while the alarm is up. Two saturating counters, one for corrected beats and one for uncorrectable beats, are available for logging. A matching encoder module is included so the sending side and the bench can build codewords.

Top module: `ecc_link_monitor`

## Requirements
- R1: out_valid equals in_valid delayed by exactly one clock. A clean beat appears unchanged on out_ctrl and out_data with out_poison low. Reset clears every output and both counters.
- R2: A single flipped bit at any codeword position of either word is corrected. The beat comes out with the original payload, the same one-cycle latency, and out_poison low.
- R3: An uncorrectable data word sets out_poison on that output beat and leaves checkstop_req unchanged. A word is uncorrectable when its syndrome is nonzero with even overall parity, or when its parity is odd and the syndrome points past the last position. Its payload bits are passed on without correction.
- R4: An uncorrectable control word raises checkstop_req from the next clock. checkstop_req then stays high until reset, and beats keep flowing.
- R5: Codeword layout:
  - Bit 0 is even parity over the whole codeword.
  - Each position 2^i holds the check bit over every other position whose index has bit i set.
  - Payload bits fill the remaining positions in ascending order, so payload bit 0 sits at position 3.
- R6: Each minute_tick shifts a flag into a HIST-deep history. The flag is 1 when any valid beat since the previous tick had a corrected word. service_alarm goes high one clock after the tick that makes the whole history ones.
- R7: Any interval without a corrected beat breaks the run. No alarm is raised until HIST consecutive intervals with corrections follow.
- R8: service_alarm is sticky across ticks and idle time. An alarm_clr pulse clears it on the next clock. A tick that completes a run in the same cycle as alarm_clr leaves it set.
- R9: While service_alarm is high, single-bit errors are still corrected and delivered.
- R10: ce_count adds one per valid beat with any corrected word, even when both words were corrected. ue_count adds one per valid beat with any uncorrectable word. Both stop at all ones.
- R11: A corrected beat in the same cycle as minute_tick counts toward the interval that tick closes.
- R12: Beats with in_valid low are ignored. They change no counter, raise no flag and produce no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present on the codeword inputs |
| in_ctrl_cw | input | CTRL_N (22) | Encoded control word |
| in_data_cw | input | DATA_N (72) | Encoded data word |
| minute_tick | input | 1 | One-cycle pulse closing an observation interval |
| alarm_clr | input | 1 | Clears the service alarm |
| out_valid | output | 1 | Decoded beat present |
| out_ctrl | output | CTRL_W | Corrected control payload |
| out_data | output | DATA_W | Corrected data payload |
| out_poison | output | 1 | Data payload of this beat is unusable |
| checkstop_req | output | 1 | Sticky request to halt after a control-word failure |
| service_alarm | output | 1 | Sticky persistent-correction alarm |
| ce_count | output | CNT_W | Saturating count of corrected beats |
| ue_count | output | CNT_W | Saturating count of uncorrectable beats |

## Verification
The bench builds the block with a 64-bit data word, a 16-bit control word, a three-interval history and a 4-bit counter width. With counters that narrow, the sweep that flips each of the 94 codeword positions in turn drives ce_count well past its ceiling, so saturation is observed directly. The three-deep history lets a short tick sequence cover several cases:
- a broken run;
- a run whose last correction lands on the tick itself;
- an alarm clear that coincides with a completing tick.

// File: rtl/ecclm_pkg.sv
package ecclm_pkg;

   // number of Hamming check bits needed for k payload bits
   function automatic int chk_bits(input int k);
      int r;
      r = 1;
      while ((1 << r) < k + r + 1) r++;
      return r;
   endfunction

   // full codeword width: payload, Hamming checks, overall parity
   function automatic int cw_bits(input int k);
      return k + chk_bits(k) + 1;
   endfunction

   // codeword position of payload bit j (skips 0 and powers of two)
   function automatic int data_pos(input int j);
      int p;
      int seen;
      p    = 0;
      seen = -1;
      while (seen < j) begin
         p++;
         if ((p & (p - 1)) != 0) seen++;
      end
      return p;
   endfunction

   typedef enum logic [1:0] {
      ECC_CLEAN = 2'd0,
      ECC_FIXED = 2'd1,
      ECC_FATAL = 2'd2
   } ecc_status_e;

endpackage

// File: rtl/ecclm_encoder.sv
module ecclm_encoder
   import ecclm_pkg::*;
#(
   parameter  int K = 64,
   localparam int R = chk_bits(K),
   localparam int N = K + R + 1
) (
   input  logic [K-1:0] data_i,
   output logic [N-1:0] cw_o
);

   if (K < 4) begin : g_bad_k
      $error("ecclm_encoder: K must be at least 4");
   end

   always_comb begin
      logic [N-1:0] c;
      c = '0;
      for (int j = 0; j < K; j++) begin
         c[data_pos(j)] = data_i[j];
      end
      for (int i = 0; i < R; i++) begin
         logic x;
         x = 1'b0;
         for (int p = 1; p < N; p++) begin
            if (((p >> i) & 1) == 1 && p != (1 << i)) x = x ^ c[p];
         end
         c[1 << i] = x;
      end
      c[0] = ^c[N-1:1];
      cw_o = c;
   end

endmodule

// File: rtl/ecclm_decoder.sv
module ecclm_decoder
   import ecclm_pkg::*;
#(
   parameter  int K = 64,
   localparam int R = chk_bits(K),
   localparam int N = K + R + 1
) (
   input  logic [N-1:0] cw_i,
   output logic [K-1:0] data_o,
   output ecc_status_e  status_o
);

   logic [K-1:0] raw_data;
   logic [N-1:0] regen;
   logic [R-1:0] synd;
   logic         odd;
   logic [N-1:0] fixed;

   // payload as received, and payload after repair
   for (genvar g = 0; g < K; g++) begin : g_map
      assign raw_data[g] = cw_i[data_pos(g)];
      assign data_o[g]   = fixed[data_pos(g)];
   end

   // re-encode the received payload; check-bit mismatches form the syndrome
   ecclm_encoder #(.K(K)) u_regen (
      .data_i (raw_data),
      .cw_o   (regen)
   );

   for (genvar i = 0; i < R; i++) begin : g_synd
      assign synd[i] = cw_i[1 << i] ^ regen[1 << i];
   end

   assign odd = ^cw_i;

   always_comb begin
      fixed    = cw_i;
      status_o = ECC_CLEAN;
      if (odd) begin
         if (int'(synd) < N) begin
            fixed[synd] = ~cw_i[synd];
            status_o    = ECC_FIXED;
         end else begin
            status_o = ECC_FATAL;
         end
      end else if (synd != '0) begin
         status_o = ECC_FATAL;
      end
   end

endmodule

// File: rtl/ecclm_persist.sv
module ecclm_persist #(
   parameter int HIST = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_evt,
   input  logic tick,
   input  logic clr,
   output logic alarm_o
);

   if (HIST < 2) begin : g_bad_hist
      $error("ecclm_persist: HIST must be at least 2");
   end

   logic            seen_q;
   logic            seen_now;
   logic [HIST-1:0] hist_q;
   logic [HIST-1:0] hist_nx;

   // a correction in the tick cycle belongs to the closing interval
   assign seen_now = seen_q | ce_evt;
   assign hist_nx  = {hist_q[HIST-2:0], seen_now};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b0;
         hist_q  <= '0;
         alarm_o <= 1'b0;
      end else begin
         if (tick) begin
            hist_q <= hist_nx;
            seen_q <= 1'b0;
         end else begin
            seen_q <= seen_now;
         end
         if (tick && (&hist_nx)) alarm_o <= 1'b1;
         else if (clr)           alarm_o <= 1'b0;
      end
   end

endmodule

// File: rtl/ecclm_sat_counter.sv
module ecclm_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count_o
);

   if (W < 2) begin : g_bad_w
      $error("ecclm_sat_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             count_o <= '0;
      else if (inc && count_o != {W{1'b1}})   count_o <= count_o + 1'b1;
   end

endmodule

// File: rtl/ecc_link_monitor.sv
module ecc_link_monitor
   import ecclm_pkg::*;
#(
   parameter  int DATA_W = 64,
   parameter  int CTRL_W = 16,
   parameter  int HIST   = 3,
   parameter  int CNT_W  = 16,
   localparam int DATA_N = cw_bits(DATA_W),
   localparam int CTRL_N = cw_bits(CTRL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CTRL_N-1:0] in_ctrl_cw,
   input  logic [DATA_N-1:0] in_data_cw,
   input  logic              minute_tick,
   input  logic              alarm_clr,
   output logic              out_valid,
   output logic [CTRL_W-1:0] out_ctrl,
   output logic [DATA_W-1:0] out_data,
   output logic              out_poison,
   output logic              checkstop_req,
   output logic              service_alarm,
   output logic [CNT_W-1:0]  ce_count,
   output logic [CNT_W-1:0]  ue_count
);

   localparam int NUM_CNT = 2;

   if (DATA_W < 4 || CTRL_W < 4) begin : g_bad_width
      $error("ecc_link_monitor: word widths must be at least 4");
   end

   logic [CTRL_W-1:0] ctrl_fix;
   logic [DATA_W-1:0] data_fix;
   ecc_status_e       ctrl_st;
   ecc_status_e       data_st;
   logic              ce_evt;
   logic              ue_evt;
   logic              ctrl_ue;
   logic              data_ue;

   ecclm_decoder #(.K(CTRL_W)) u_ctrl_dec (
      .cw_i     (in_ctrl_cw),
      .data_o   (ctrl_fix),
      .status_o (ctrl_st)
   );

   ecclm_decoder #(.K(DATA_W)) u_data_dec (
      .cw_i     (in_data_cw),
      .data_o   (data_fix),
      .status_o (data_st)
   );

   assign ctrl_ue = (ctrl_st == ECC_FATAL);
   assign data_ue = (data_st == ECC_FATAL);
   assign ce_evt  = in_valid & ((ctrl_st == ECC_FIXED) | (data_st == ECC_FIXED));
   assign ue_evt  = in_valid & (ctrl_ue | data_ue);

   // single output stage shared by clean and corrected beats
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_ctrl      <= '0;
         out_data      <= '0;
         out_poison    <= 1'b0;
         checkstop_req <= 1'b0;
      end else begin
         out_valid  <= in_valid;
         out_poison <= in_valid & data_ue;
         if (in_valid) begin
            out_ctrl <= ctrl_fix;
            out_data <= data_fix;
         end
         if (in_valid && ctrl_ue) checkstop_req <= 1'b1;
      end
   end

   ecclm_persist #(.HIST(HIST)) u_persist (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_evt  (ce_evt),
      .tick    (minute_tick),
      .clr     (alarm_clr),
      .alarm_o (service_alarm)
   );

   logic [NUM_CNT-1:0] cnt_inc;
   logic [CNT_W-1:0]   cnt_val [NUM_CNT];

   assign cnt_inc = {ue_evt, ce_evt};

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      ecclm_sat_counter #(.W(CNT_W)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (cnt_inc[g]),
         .count_o (cnt_val[g])
      );
   end

   assign ce_count = cnt_val[0];
   assign ue_count = cnt_val[1];

endmodule

// File: rtl/ecc_link_monitor_chk.sv
module ecc_link_monitor_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             minute_tick,
   input logic             alarm_clr,
   input logic             out_valid,
   input logic             out_poison,
   input logic             checkstop_req,
   input logic             service_alarm,
   input logic [CNT_W-1:0] ce_count,
   input logic [CNT_W-1:0] ue_count
);

   assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   assert_poison_on_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_poison |-> out_valid);

   assert_checkstop_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop_req |=> checkstop_req);

   assert_alarm_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(service_alarm) |-> $past(minute_tick));

   assert_alarm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_clr && !minute_tick) |=> !service_alarm);

   assert_ce_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (ce_count >= $past(ce_count)));

   assert_ce_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_count == {CNT_W{1'b1}}) |=> (ce_count == {CNT_W{1'b1}}));

   assert_idle_no_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(ce_count) && $stable(ue_count)));

endmodule

bind ecc_link_monitor ecc_link_monitor_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .minute_tick   (minute_tick),
   .alarm_clr     (alarm_clr),
   .out_valid     (out_valid),
   .out_poison    (out_poison),
   .checkstop_req (checkstop_req),
   .service_alarm (service_alarm),
   .ce_count      (ce_count),
   .ue_count      (ue_count)
);

// File: tb/ecc_link_monitor_test.sv
module ecc_link_monitor_test;
   import ecclm_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 64;
   localparam int CW   = 16;
   localparam int HIST = 3;
   localparam int CNT  = 4;
   localparam int DN   = cw_bits(DW);
   localparam int CN   = cw_bits(CW);

   logic          clk;
   logic          rst_n;
   logic          in_valid;
   logic [CN-1:0] in_ctrl_cw;
   logic [DN-1:0] in_data_cw;
   logic          minute_tick;
   logic          alarm_clr;
   logic          out_valid;
   logic [CW-1:0] out_ctrl;
   logic [DW-1:0] out_data;
   logic          out_poison;
   logic          checkstop_req;
   logic          service_alarm;
   logic [CNT-1:0] ce_count;
   logic [CNT-1:0] ue_count;

   logic [DW-1:0] enc_in;
   logic [DN-1:0] enc_out;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;

   ecc_link_monitor #(
      .DATA_W(DW), .CTRL_W(CW), .HIST(HIST), .CNT_W(CNT)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_ctrl_cw    (in_ctrl_cw),
      .in_data_cw    (in_data_cw),
      .minute_tick   (minute_tick),
      .alarm_clr     (alarm_clr),
      .out_valid     (out_valid),
      .out_ctrl      (out_ctrl),
      .out_data      (out_data),
      .out_poison    (out_poison),
      .checkstop_req (checkstop_req),
      .service_alarm (service_alarm),
      .ce_count      (ce_count),
      .ue_count      (ue_count)
   );

   ecclm_encoder #(.K(DW)) u_enc (
      .data_i (enc_in),
      .cw_o   (enc_out)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // codeword built from the layout rule of R5
   function automatic logic [127:0] ref_enc(input logic [63:0] d, input int k);
      logic [127:0] c;
      int r, n, j;
      logic x;
      r = 1;
      while ((1 << r) < k + r + 1) r++;
      n = k + r + 1;
      c = '0;
      j = 0;
      for (int p = 1; p < n; p++) begin
         if ((p & (p - 1)) != 0) begin
            c[p] = d[j];
            j++;
         end
      end
      for (int i = 0; i < r; i++) begin
         x = 1'b0;
         for (int p = 1; p < n; p++) begin
            if (((p >> i) & 1) == 1 && p != (1 << i)) x = x ^ c[p];
         end
         c[1 << i] = x;
      end
      c[0] = ^c;
      return c;
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   typedef struct {
      logic [CW-1:0] c;
      logic [DW-1:0] d;
      logic          p;
      string         tag;
   } exp_t;

   exp_t sb[$];

   task automatic beat(input logic [CW-1:0] c, input logic [DW-1:0] d,
                       input logic [CN-1:0] cm, input logic [DN-1:0] dm,
                       input logic exp_p, input logic tk, input string tag);
      logic [127:0] ec;
      logic [127:0] ed;
      @(negedge clk);
      ec = ref_enc({48'b0, c}, CW);
      ed = ref_enc(d, DW);
      in_valid    = 1'b1;
      in_ctrl_cw  = ec[CN-1:0] ^ cm;
      in_data_cw  = ed[DN-1:0] ^ dm;
      minute_tick = tk;
      alarm_clr   = 1'b0;
      sb.push_back('{c: c, d: d, p: exp_p, tag: tag});
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid    = 1'b0;
      minute_tick = 1'b0;
      alarm_clr   = 1'b0;
   endtask

   task automatic tick_pulse(input logic clr);
      @(negedge clk);
      in_valid    = 1'b0;
      minute_tick = 1'b1;
      alarm_clr   = clr;
   endtask

   task automatic clr_pulse();
      @(negedge clk);
      in_valid    = 1'b0;
      minute_tick = 1'b0;
      alarm_clr   = 1'b1;
   endtask

   // single-bit data error at position 7, used as a generic corrected beat
   task automatic ce_beat(input logic tk, input string tag);
      logic [DN-1:0] dm;
      dm = '0;
      dm[7] = 1'b1;
      beat(16'h0F0F, 64'h1357_9BDF_2468_ACE0, '0, dm, 1'b0, tk, tag);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R1 unexpected beat actual=%0h expected=none", out_data);
         end else begin
            e = sb.pop_front();
            chk({e.tag, " ctrl"},   128'(out_ctrl),   128'(e.c));
            chk({e.tag, " data"},   128'(out_data),   128'(e.d));
            chk({e.tag, " poison"}, 128'(out_poison), 128'(e.p));
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      rst_n       = 1'b0;
      in_valid    = 1'b0;
      in_ctrl_cw  = '0;
      in_data_cw  = '0;
      minute_tick = 1'b0;
      alarm_clr   = 1'b0;
      enc_in      = '0;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk("R1 reset out_valid", 128'(out_valid), 0);
      chk("R1 reset poison",    128'(out_poison), 0);
      chk("R1 reset checkstop", 128'(checkstop_req), 0);
      chk("R1 reset alarm",     128'(service_alarm), 0);
      chk("R1 reset ce_count",  128'(ce_count), 0);
      chk("R1 reset ue_count",  128'(ue_count), 0);
      rst_n = 1'b1;

      // R5 encoder layout
      enc_in = 64'h1;
      #1;
      chk("R5 payload bit0 codeword", 128'(enc_out), 128'hF);
      enc_in = 64'hDEAD_BEEF_0123_4567;
      #1;
      chk("R5 encoder vs layout", 128'(enc_out), ref_enc(64'hDEAD_BEEF_0123_4567, DW) & {{(128-DN){1'b0}}, {DN{1'b1}}});

      // R1 clean beats
      beat(16'h0000, 64'h0, '0, '0, 1'b0, 1'b0, "R1");
      beat(16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, 1'b0, 1'b0, "R1");
      beat(16'hA5C3, 64'h0123_4567_89AB_CDEF, '0, '0, 1'b0, 1'b0, "R1");
      idle();
      chk("R1 no ce on clean", 128'(ce_count), 0);

      // R2 / R10 single data correction
      begin
         logic [DN-1:0] dm;
         dm = '0;
         dm[5] = 1'b1;
         beat(16'h1111, 64'hCAFE_F00D_0000_0001, '0, dm, 1'b0, 1'b0, "R2");
      end
      idle();
      chk("R10 ce_count one", 128'(ce_count), 1);

      // R10 both words corrected in one beat counts once
      begin
         logic [CN-1:0] cm;
         logic [DN-1:0] dm;
         cm = '0;
         cm[0] = 1'b1;
         dm = '0;
         dm[DN-1] = 1'b1;
         beat(16'h2222, 64'h8000_0000_0000_0000, cm, dm, 1'b0, 1'b0, "R2");
      end
      idle();
      chk("R10 ce_count per beat", 128'(ce_count), 2);

      // R3 data uncorrectable: flip check positions 1 and 2
      begin
         logic [DN-1:0] dm;
         dm = '0;
         dm[1] = 1'b1;
         dm[2] = 1'b1;
         beat(16'h3333, 64'h5555_AAAA_5555_AAAA, '0, dm, 1'b1, 1'b0, "R3");
      end
      idle();
      chk("R3 no checkstop on data ue", 128'(checkstop_req), 0);
      chk("R10 ue_count one", 128'(ue_count), 1);

      // R12 invalid beat carrying errors
      begin
         logic [127:0] ec;
         logic [127:0] ed;
         @(negedge clk);
         ec = ref_enc(64'h4444, CW);
         ed = ref_enc(64'h77, DW);
         in_valid   = 1'b0;
         in_ctrl_cw = ec[CN-1:0] ^ CN'(18);
         in_data_cw = ed[DN-1:0] ^ DN'(32);
      end
      idle();
      chk("R12 no output beat", 128'(out_valid), 0);
      chk("R12 ce unchanged", 128'(ce_count), 2);
      chk("R12 ue unchanged", 128'(ue_count), 1);
      chk("R12 no checkstop", 128'(checkstop_req), 0);

      // R2 sweep every position of both words
      for (int k = 0; k < DN; k++) begin
         logic [DN-1:0] dm;
         dm = '0;
         dm[k] = 1'b1;
         beat(16'h5A5A, 64'hA5A5_0000_FFFF_1234 ^ 64'(k), '0, dm, 1'b0, 1'b0, "R2");
      end
      for (int k = 0; k < CN; k++) begin
         logic [CN-1:0] cm;
         cm = '0;
         cm[k] = 1'b1;
         beat(16'h1234 + 16'(k), 64'h0F0F_F0F0_3C3C_C3C3, cm, '0, 1'b0, 1'b0, "R2");
      end
      idle();
      chk("R10 ce_count saturated", 128'(ce_count), 15);

      // R6 / R7 / R11 persistence: seen flag is set at this point
      tick_pulse(1'b0);                        // history 001
      idle();
      chk("R6 no alarm after one", 128'(service_alarm), 0);
      ce_beat(1'b1, "R11");                    // history 011
      idle();
      chk("R6 no alarm after two", 128'(service_alarm), 0);
      tick_pulse(1'b0);                        // history 110
      idle();
      chk("R7 gap interval", 128'(service_alarm), 0);
      ce_beat(1'b0, "R7");
      tick_pulse(1'b0);                        // history 101
      ce_beat(1'b0, "R7");
      tick_pulse(1'b0);                        // history 011
      idle();
      chk("R7 run broken", 128'(service_alarm), 0);
      ce_beat(1'b1, "R11");                    // history 111
      idle();
      chk("R11 tick-cycle ce completes run", 128'(service_alarm), 1);

      // R8 sticky
      repeat (5) idle();
      chk("R8 sticky idle", 128'(service_alarm), 1);
      tick_pulse(1'b0);                        // history 110
      idle();
      chk("R8 sticky over quiet tick", 128'(service_alarm), 1);

      // R9 correction while alarm raised
      ce_beat(1'b0, "R9");
      idle();
      chk("R9 alarm held", 128'(service_alarm), 1);

      // R8 clear, then set wins over clear
      clr_pulse();
      idle();
      chk("R8 cleared", 128'(service_alarm), 0);
      tick_pulse(1'b0);                        // history 101
      idle();
      chk("R8 stays clear", 128'(service_alarm), 0);
      ce_beat(1'b0, "R8");
      tick_pulse(1'b0);                        // history 011
      ce_beat(1'b0, "R8");
      tick_pulse(1'b1);                        // history 111 with clear
      idle();
      chk("R8 set wins over clear", 128'(service_alarm), 1);

      // R4 control uncorrectable: flip check positions 1 and 4
      begin
         logic [CN-1:0] cm;
         cm = '0;
         cm[1] = 1'b1;
         cm[4] = 1'b1;
         beat(16'hBEEF, 64'h1111_2222_3333_4444, cm, '0, 1'b0, 1'b0, "R4");
      end
      idle();
      chk("R4 checkstop raised", 128'(checkstop_req), 1);
      chk("R10 ue_count two", 128'(ue_count), 2);
      repeat (4) idle();
      chk("R4 checkstop sticky", 128'(checkstop_req), 1);
      beat(16'h7777, 64'h9999_8888_7777_6666, '0, '0, 1'b0, 1'b0, "R4");
      idle();
      idle();
      chk("R1 scoreboard drained", 128'(sb.size()), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule